// File: doc/BRIEF.md
# Segment Offset Limit Checker

The block sits in front of the paging stage of an address translation pipeline. For each memory request it takes the virtual address, the base and limit of the selected segment, that segment's expand-down and big attributes, the access byte count, the access mode and a request-flags word. From these it forms the segment offset and checks the accessed byte range against the segment bounds. It also produces the linear address that paging consumes and says whether the request runs with user privilege.

The width of the offset is not inferred from processor defaults or prefixes. Each request carries a 2-bit address-size code in its flags word, and data accesses mask the offset to that width. Instruction fetches carry no size information, so they skip the mask. In 64-bit submode the limit check is suppressed. In that submode only the two segments that keep a base (code 4 and code 5) subtract a base at all.

The datapath is combinational and feeds one output register stage. A request is presented with `req_valid_i` high. The results appear on the outputs one clock later, with `rsp_valid_o` high.

Top module: `seg_limit_chk`

## Requirements
- R1: The flags word is decoded as follows: bits 3:0 are the segment code and are reported on `seg_o`, bit 4 forces supervisor privilege, and bits 6:5 carry the address-size code.
- R2: The address width in bits is 8 shifted left by the size code: code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 64.
- R3: For reads (`mode_i` = 1) and writes (`mode_i` = 2), `offset_o` is (virtual address − base) masked to the address width.
- R4: For instruction fetches (`mode_i` = 0), `offset_o` is (virtual address − base) with no mask applied.
- R5: For a normal segment (`expand_down_i` = 0), let end = offset + byte count − 1, computed modulo 2^64. `limit_fault_o` is raised when end exceeds the zero-extended limit, or when end is below the offset (wrap).
- R6: For an expand-down segment, `limit_fault_o` is raised when the offset is less than or equal to the limit, when end exceeds the upper bound, or when end wraps. The upper bound is 0xFFFF when `big_i` = 0 and 0xFFFFFFFF when `big_i` = 1.
- R7: `lin_addr_o` equals the virtual address with bits 63:32 cleared, unless `long_mode_i` is high or the size code is 3; in those cases it is passed through unchanged.
- R8: `user_o` is high only when `cpl_i` = 3 and the force-supervisor bit is clear.
- R9: When `long_mode_i` is high, `limit_fault_o` is low. In that mode the base is subtracted only for segment codes 4 and 5; every other segment uses a base of zero.
- R10: Results are registered. A request with `req_valid_i` high updates every result output on the next rising edge, and `rsp_valid_o` is high for exactly that cycle. Without a request the result outputs hold. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| vaddr_i | input | 64 | Virtual address |
| seg_base_i | input | 64 | Segment base |
| seg_limit_i | input | 32 | Segment limit |
| expand_down_i | input | 1 | Segment grows downward |
| big_i | input | 1 | Expand-down upper bound select |
| acc_bytes_i | input | 4 | Access byte count (1 or more) |
| mode_i | input | 2 | 0 fetch, 1 read, 2 write |
| flags_i | input | 8 | Request flags word |
| cpl_i | input | 2 | Current privilege level |
| long_mode_i | input | 1 | Core is in 64-bit submode |
| rsp_valid_o | output | 1 | Result valid |
| offset_o | output | 64 | Segment offset |
| limit_fault_o | output | 1 | Limit violation |
| lin_addr_o | output | 64 | Linear address for paging |
| user_o | output | 1 | Request runs at user privilege |
| seg_o | output | 4 | Decoded segment code |

## Verification
The bench builds the block with its default parameters: a 64-bit address path, a 32-bit limit and a 4-bit byte count. These widths bring a true 2^64 wrap of the end offset within reach, and that wrap can only occur on unmasked fetches or with size code 3. The widths also allow every one of the four size codes to be exercised against the same limit port. Random requests place the offset close to the limit, so that both sides of each bound are hit. Directed cases cover the exact boundaries: offset equal to the limit in an expand-down segment, end exactly at the 16-bit upper bound, and wraps of the masked and unmasked offsets.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_mode_e;

  localparam int unsigned FLG_SEG_LSB = 0;
  localparam int unsigned FLG_SEG_W   = 4;
  localparam int unsigned FLG_SUP_BIT = 4;
  localparam int unsigned FLG_ASZ_LSB = 5;
  localparam int unsigned FLG_ASZ_W   = 2;

  // segments that keep a base in 64-bit submode
  localparam logic [FLG_SEG_W-1:0] SEG_KEEP_A = 4'd4;
  localparam logic [FLG_SEG_W-1:0] SEG_KEEP_B = 4'd5;
endpackage

// File: rtl/seg_flag_decode.sv
module seg_flag_decode
  import seg_chk_pkg::*;
#(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned FLG_W = 8
) (
  input  logic [FLG_W-1:0]     flags_i,
  output logic [FLG_SEG_W-1:0] seg_o,
  output logic                 force_sup_o,
  output logic [FLG_ASZ_W-1:0] asz_o,
  output logic [VA_W-1:0]      width_mask_o,
  output logic                 full_width_o
);
  localparam int unsigned NUM_ASZ = 1 << FLG_ASZ_W;

  logic [NUM_ASZ-1:0][VA_W-1:0] mask_tab;

  assign seg_o       = flags_i[FLG_SEG_LSB +: FLG_SEG_W];
  assign force_sup_o = flags_i[FLG_SUP_BIT];
  assign asz_o       = flags_i[FLG_ASZ_LSB +: FLG_ASZ_W];

  // one mask per size code: width = 8 << code
  for (genvar g = 0; g < NUM_ASZ; g++) begin : g_mask
    localparam int unsigned BITS = 8 << g;
    for (genvar b = 0; b < VA_W; b++) begin : g_bit
      assign mask_tab[g][b] = (b < BITS);
    end
  end

  assign width_mask_o = mask_tab[asz_o];
  assign full_width_o = (asz_o == FLG_ASZ_W'(NUM_ASZ - 1));
endmodule

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned CNT_W = 4
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [VA_W-1:0]  base_i,
  input  logic             use_base_i,
  input  logic             fetch_i,
  input  logic [VA_W-1:0]  width_mask_i,
  input  logic [CNT_W-1:0] bytes_i,
  output logic [VA_W-1:0]  offset_o,
  output logic [VA_W-1:0]  end_o,
  output logic             wrap_o
);
  logic [VA_W-1:0] eff_base;
  logic [VA_W-1:0] diff;

  assign eff_base = use_base_i ? base_i : '0;
  assign diff     = vaddr_i - eff_base;
  assign offset_o = fetch_i ? diff : (diff & width_mask_i);
  assign end_o    = offset_o + VA_W'(bytes_i) - VA_W'(1);
  assign wrap_o   = (end_o < offset_o);
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned LIM_W = 32
) (
  input  logic [VA_W-1:0]  offset_i,
  input  logic [VA_W-1:0]  end_i,
  input  logic             wrap_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             expand_down_i,
  input  logic             big_i,
  input  logic             bypass_i,
  output logic             fault_o
);
  localparam logic [VA_W-1:0] UPPER_SMALL = VA_W'(16'hFFFF);
  localparam logic [VA_W-1:0] UPPER_BIG   = VA_W'(32'hFFFF_FFFF);

  logic [VA_W-1:0] lim_ext;
  logic [VA_W-1:0] upper;
  logic            up_fault;
  logic            dn_fault;

  assign lim_ext  = VA_W'(limit_i);
  assign upper    = big_i ? UPPER_BIG : UPPER_SMALL;
  assign up_fault = (end_i > lim_ext) || wrap_i;
  assign dn_fault = (offset_i <= lim_ext) || (end_i > upper) || wrap_i;
  assign fault_o  = !bypass_i && (expand_down_i ? dn_fault : up_fault);
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_chk_pkg::*;
#(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned LIM_W = 32,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned FLG_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      vaddr_i,
  input  logic [VA_W-1:0]      seg_base_i,
  input  logic [LIM_W-1:0]     seg_limit_i,
  input  logic                 expand_down_i,
  input  logic                 big_i,
  input  logic [CNT_W-1:0]     acc_bytes_i,
  input  logic [1:0]           mode_i,
  input  logic [FLG_W-1:0]     flags_i,
  input  logic [1:0]           cpl_i,
  input  logic                 long_mode_i,
  output logic                 rsp_valid_o,
  output logic [VA_W-1:0]      offset_o,
  output logic                 limit_fault_o,
  output logic [VA_W-1:0]      lin_addr_o,
  output logic                 user_o,
  output logic [FLG_SEG_W-1:0] seg_o
);
  localparam logic [VA_W-1:0] LOW32_MASK = VA_W'(32'hFFFF_FFFF);
  localparam logic [1:0]      CPL_USER   = 2'd3;

  logic [FLG_SEG_W-1:0] seg_d;
  logic                 force_sup;
  logic [FLG_ASZ_W-1:0] asz;
  logic [VA_W-1:0]      width_mask;
  logic                 full_width;
  logic                 keeps_base;
  logic                 use_base;
  logic                 is_fetch;
  logic [VA_W-1:0]      offset_d;
  logic [VA_W-1:0]      end_d;
  logic                 wrap_d;
  logic                 fault_d;
  logic [VA_W-1:0]      lin_d;
  logic                 user_d;

  seg_flag_decode #(
    .VA_W (VA_W),
    .FLG_W(FLG_W)
  ) i_dec (
    .flags_i     (flags_i),
    .seg_o       (seg_d),
    .force_sup_o (force_sup),
    .asz_o       (asz),
    .width_mask_o(width_mask),
    .full_width_o(full_width)
  );

  assign keeps_base = (seg_d == SEG_KEEP_A) || (seg_d == SEG_KEEP_B);
  assign use_base   = !long_mode_i || keeps_base;
  assign is_fetch   = (acc_mode_e'(mode_i) == ACC_FETCH);

  seg_offset_calc #(
    .VA_W (VA_W),
    .CNT_W(CNT_W)
  ) i_ofs (
    .vaddr_i     (vaddr_i),
    .base_i      (seg_base_i),
    .use_base_i  (use_base),
    .fetch_i     (is_fetch),
    .width_mask_i(width_mask),
    .bytes_i     (acc_bytes_i),
    .offset_o    (offset_d),
    .end_o       (end_d),
    .wrap_o      (wrap_d)
  );

  seg_bound_check #(
    .VA_W (VA_W),
    .LIM_W(LIM_W)
  ) i_bnd (
    .offset_i     (offset_d),
    .end_i        (end_d),
    .wrap_i       (wrap_d),
    .limit_i      (seg_limit_i),
    .expand_down_i(expand_down_i),
    .big_i        (big_i),
    .bypass_i     (long_mode_i),
    .fault_o      (fault_d)
  );

  assign lin_d  = (long_mode_i || full_width) ? vaddr_i : (vaddr_i & LOW32_MASK);
  assign user_d = (cpl_i == CPL_USER) && !force_sup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      offset_o      <= '0;
      limit_fault_o <= 1'b0;
      lin_addr_o    <= '0;
      user_o        <= 1'b0;
      seg_o         <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        offset_o      <= offset_d;
        limit_fault_o <= fault_d;
        lin_addr_o    <= lin_d;
        user_o        <= user_d;
        seg_o         <= seg_d;
      end
    end
  end
endmodule

// File: rtl/seg_limit_chk_sva.sv
module seg_limit_chk_sva #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned LIM_W = 32,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned FLG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       mode_i,
  input logic [FLG_W-1:0] flags_i,
  input logic [1:0]       cpl_i,
  input logic             long_mode_i,
  input logic             rsp_valid_o,
  input logic [VA_W-1:0]  offset_o,
  input logic             limit_fault_o,
  input logic [VA_W-1:0]  lin_addr_o,
  input logic             user_o
);
  AST_LONG_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && long_mode_i |=> !limit_fault_o); // R9

  AST_SUPER_NOT_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (cpl_i != 2'd3 || flags_i[4]) |=> !user_o); // R8

  AST_LIN_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !long_mode_i && flags_i[6:5] != 2'd3 |=> lin_addr_o[VA_W-1:32] == '0); // R7

  AST_OFS_16BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i != 2'd0 && flags_i[6:5] == 2'd1 |=> offset_o[VA_W-1:16] == '0); // R3

  AST_OFS_8BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i != 2'd0 && flags_i[6:5] == 2'd0 |=> offset_o[VA_W-1:8] == '0); // R2

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R10

  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && $stable(offset_o) && $stable(limit_fault_o)); // R10
endmodule

bind seg_limit_chk seg_limit_chk_sva #(
  .VA_W (VA_W),
  .LIM_W(LIM_W),
  .CNT_W(CNT_W),
  .FLG_W(FLG_W)
) i_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .mode_i       (mode_i),
  .flags_i      (flags_i),
  .cpl_i        (cpl_i),
  .long_mode_i  (long_mode_i),
  .rsp_valid_o  (rsp_valid_o),
  .offset_o     (offset_o),
  .limit_fault_o(limit_fault_o),
  .lin_addr_o   (lin_addr_o),
  .user_o       (user_o)
);

// File: tb/test_seg_limit_chk.sv
`timescale 1ns/1ps
module test_seg_limit_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [63:0] base = '0;
  logic [31:0] limit = '0;
  logic        exp_dn = 1'b0;
  logic        big = 1'b0;
  logic [3:0]  nbytes = 4'd1;
  logic [1:0]  mode = 2'd1;
  logic [7:0]  flags = '0;
  logic [1:0]  cpl = '0;
  logic        lmode = 1'b0;
  logic        rsp_valid;
  logic [63:0] offset;
  logic        fault;
  logic [63:0] lin;
  logic        user;
  logic [3:0]  seg;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  seg_limit_chk i_seg_limit_chk (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .vaddr_i(vaddr), .seg_base_i(base), .seg_limit_i(limit),
    .expand_down_i(exp_dn), .big_i(big), .acc_bytes_i(nbytes),
    .mode_i(mode), .flags_i(flags), .cpl_i(cpl), .long_mode_i(lmode),
    .rsp_valid_o(rsp_valid), .offset_o(offset), .limit_fault_o(fault),
    .lin_addr_o(lin), .user_o(user), .seg_o(seg)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_offset();
    logic [63:0] b, d, msk;
    logic keep;
    keep = (flags[3:0] == 4'd4) || (flags[3:0] == 4'd5);
    b = (lmode && !keep) ? 64'd0 : base;
    d = vaddr - b;
    case (flags[6:5])
      2'd0: msk = 64'hFF;
      2'd1: msk = 64'hFFFF;
      2'd2: msk = 64'hFFFF_FFFF;
      default: msk = '1;
    endcase
    return (mode == 2'd0) ? d : (d & msk);
  endfunction

  function automatic logic m_fault();
    logic [63:0] o, e, up;
    o = m_offset();
    e = o + 64'(nbytes) - 64'd1;
    up = big ? 64'hFFFF_FFFF : 64'hFFFF;
    if (lmode) return 1'b0;
    if (exp_dn) return (o <= 64'(limit)) || (e > up) || (e < o);
    return (e > 64'(limit)) || (e < o);
  endfunction

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run_req(input string tag);
    logic [63:0] e_ofs, e_lin;
    logic e_flt, e_usr;
    e_ofs = m_offset();
    e_flt = m_fault();
    e_lin = (lmode || flags[6:5] == 2'd3) ? vaddr : {32'd0, vaddr[31:0]};
    e_usr = (cpl == 2'd3) && !flags[4];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10"}, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk({tag, " R3 R4"}, "offset", offset, e_ofs);
    chk({tag, " R5 R6 R9"}, "fault", 64'(fault), 64'(e_flt));
    chk({tag, " R7"}, "lin", lin, e_lin);
    chk({tag, " R8"}, "user", 64'(user), 64'(e_usr));
    chk({tag, " R1"}, "seg", 64'(seg), 64'(flags[3:0]));
  endtask

  task automatic setup(input logic [63:0] va, input logic [63:0] bs, input logic [31:0] lim,
                       input logic ed, input logic bg, input logic [3:0] nb, input logic [1:0] md,
                       input logic [7:0] fl, input logic [1:0] cp, input logic lm);
    vaddr = va; base = bs; limit = lim; exp_dn = ed; big = bg; nbytes = nb;
    mode = md; flags = fl; cpl = cp; lmode = lm;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // reset state, R10
    chk("R10 reset", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset", "offset", offset, 64'd0);
    chk("R10 reset", "fault", 64'(fault), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: 16-bit data read masks the difference
    setup(64'h1_2345, 64'h0, 32'hFFFF, 0, 0, 4'd2, 2'd1, 8'b0_01_0_0011, 2'd3, 0);
    run_req("dir16");
    chk("R2 R3", "masked ofs", offset, 64'h2345);
    // R2: 8-bit width
    setup(64'h1FF, 64'h1, 32'hFF, 0, 0, 4'd1, 2'd2, 8'b0_00_0_0011, 2'd0, 0);
    run_req("dir8");
    chk("R2", "8bit ofs", offset, 64'hFE);
    // R4: fetch keeps full difference; end wraps past 2^64 -> fault (R5)
    setup(64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 32'hFFFF_FFFF, 0, 0, 4'd4, 2'd0, 8'b0_01_0_0001, 2'd3, 0);
    run_req("fetchwrap");
    chk("R4", "fetch ofs", offset, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R5", "wrap fault", 64'(fault), 64'd1);
    // R5: end exactly at limit -> ok, one beyond -> fault
    setup(64'h1000, 64'h0, 32'h1003, 0, 0, 4'd4, 2'd1, 8'b0_10_0_0011, 2'd0, 0);
    run_req("lim_eq");
    chk("R5", "end==limit", 64'(fault), 64'd0);
    setup(64'h1001, 64'h0, 32'h1003, 0, 0, 4'd4, 2'd1, 8'b0_10_0_0011, 2'd0, 0);
    run_req("lim_gt");
    chk("R5", "end>limit", 64'(fault), 64'd1);
    // R6: expand-down boundaries
    setup(64'h100, 64'h0, 32'h100, 1, 0, 4'd1, 2'd1, 8'b0_01_0_0010, 2'd0, 0);
    run_req("dn_eq");
    chk("R6", "ofs==limit", 64'(fault), 64'd1);
    setup(64'h101, 64'h0, 32'h100, 1, 0, 4'd1, 2'd1, 8'b0_01_0_0010, 2'd0, 0);
    run_req("dn_above");
    chk("R6", "ofs>limit", 64'(fault), 64'd0);
    setup(64'hFFFF, 64'h0, 32'h100, 1, 0, 4'd2, 2'd1, 8'b0_10_0_0010, 2'd0, 0);
    run_req("dn_small_top");
    chk("R6", "past 0xFFFF", 64'(fault), 64'd1);
    setup(64'hFFFF, 64'h0, 32'h100, 1, 1, 4'd2, 2'd1, 8'b0_10_0_0010, 2'd0, 0);
    run_req("dn_big_top");
    chk("R6", "big bound ok", 64'(fault), 64'd0);
    // R9: long mode, base ignored for seg 3, used for seg 5, no fault
    setup(64'h5000, 64'h1000, 32'h0, 0, 0, 4'd8, 2'd1, 8'b0_11_0_0011, 2'd3, 1);
    run_req("long_ds");
    chk("R9", "no base", offset, 64'h5000);
    chk("R9", "no fault", 64'(fault), 64'd0);
    setup(64'h5000, 64'h1000, 32'h0, 0, 0, 4'd8, 2'd1, 8'b0_11_0_0101, 2'd3, 1);
    run_req("long_gs");
    chk("R9", "kept base", offset, 64'h4000);
    // R7: size code 3 outside long mode passes upper bits
    setup(64'hABCD_0000_1234_5678, 64'h0, 32'hFFFF_FFFF, 0, 0, 4'd1, 2'd1, 8'b0_11_0_0000, 2'd0, 0);
    run_req("wide");
    chk("R7", "lin wide", lin, 64'hABCD_0000_1234_5678);
    // R8: force supervisor at ring 3
    setup(64'h10, 64'h0, 32'hFFFF, 0, 0, 4'd1, 2'd1, 8'b0_01_1_0011, 2'd3, 0);
    run_req("forcesup");
    chk("R8", "user forced off", 64'(user), 64'd0);
    // R10: idle cycle holds results
    setup(64'h7777, 64'h0, 32'h0, 0, 0, 4'd1, 2'd1, 8'b0_01_0_0011, 2'd3, 0);
    @(negedge clk);
    chk("R10", "idle valid", 64'(rsp_valid), 64'd0);
    chk("R10", "idle hold", offset, 64'h10);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] bs;
      logic [31:0] lim;
      bs  = ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom(), $urandom()};
      lim = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 32'h2_0000)) : $urandom();
      setup(bs + 64'(lim) + 64'($signed(32'($urandom_range(0, 16)) - 32'd8)), bs, lim,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom_range(1, 8)),
            2'($urandom_range(0, 2)), 8'($urandom()), 2'($urandom_range(0, 3)),
            ($urandom_range(0, 4) == 0));
      run_req("rnd");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule